// File: doc/BRIEF.md
# Guest-Stage TLB Invalidation Controller

This block keeps a small fully associative cache of first-stage guest translations and removes entries from it on request. A request carries two register operands, a guest virtual address and an address-space ID, each with a flag showing that it came from the zero register. A flagged operand acts as a wildcard. Matching is always limited to the virtual machine ID of the current virtualization context. The second operand is never read as a VMID.

Before it touches anything, the block checks legality against the current privilege level, the virtualization mode and two extension enables. A request that fails the check is turned into a one-cycle illegal-instruction or virtual-instruction indication, and the cache is left as it was. A legal request clears every matching entry in one cycle and then gives a one-cycle done pulse. Memory ordering is left to other logic.

A fill port writes new entries. It holds off while a request is being taken or cleared. A lookup port lets the surrounding pipeline, and the bench, see which entries are present under the current VMID.

Top module: `gvs_tlb_inval`

## Requirements
- R1: With `req_addr_x0` high, entries are selected whatever their page number, subject to the ASID and VMID filters.
- R2: With `req_asid_x0` high, entries are selected whatever their ASID, including global entries, subject to the address and VMID filters.
- R3: Only entries whose VMID equals `cur_vmid` at acceptance are cleared. Entries of any other VMID stay, whatever value the ASID operand holds.
- R4: Encoding of `cur_priv`: 0 is user, 1 is supervisor, 3 is machine. A request with `cur_virt` high and `cur_priv` of 0 or 1 gives an `exc_virtual` pulse, no done, and no entry change.
- R5: If `ext_h_en` or `ext_inval_en` is low, a request gives an `exc_illegal` pulse, no done, and no entry change. This check ranks above R4 and R6.
- R6: A request with `cur_virt` low and `cur_priv` of 0 gives an `exc_illegal` pulse and leaves all entries unchanged. Machine or supervisor mode with `cur_virt` low is legal.
- R7: A global entry (`fill_global` high) is not cleared by a request that names a specific ASID. It is cleared only when `req_asid_x0` is high.
- R8: Only address bits [38:12] take part in the address compare. The low 12 offset bits of `req_addr` are ignored.
- R9: If a request is accepted at clock edge k, a legal request clears its entries at edge k+1 and `done` is high for exactly the one cycle after that edge. An exception pulse is high for exactly the one cycle after edge k. Each request gives exactly one of these outcomes.
- R10: `fill_ready` is low while `req_valid` is high with the block idle, and for the whole clear cycle. A fill waiting at that time is written only after the clear, so the clear cannot remove it.
- R11: A fill writes the lowest-numbered invalid entry. When all entries are valid, it replaces a round-robin victim that starts at entry 0 after reset and moves on only when a valid entry is replaced.
- R12: `lk_hit` is high when some valid entry has VMID equal to `cur_vmid`, page number equal to `lk_vpn`, and either ASID equal to `lk_asid` or the global bit set. `lk_ppn` gives the frame of the lowest-numbered such entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Invalidation request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | 39 | Guest virtual address operand |
| req_asid_op | input | 64 | ASID operand register value, low 16 bits used |
| req_addr_x0 | input | 1 | Address operand is the zero register |
| req_asid_x0 | input | 1 | ASID operand is the zero register |
| cur_priv | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| cur_virt | input | 1 | Virtualization mode on |
| cur_vmid | input | 14 | VMID of the current context |
| ext_h_en | input | 1 | Hypervisor extension enabled |
| ext_inval_en | input | 1 | Fine-grained invalidation extension enabled |
| fill_valid | input | 1 | Fill request present |
| fill_ready | output | 1 | Fill accepted this cycle |
| fill_vpn | input | 27 | Guest virtual page number of fill |
| fill_asid | input | 16 | ASID of fill |
| fill_global | input | 1 | Fill entry is global |
| fill_ppn | input | 44 | Frame number of fill |
| lk_vpn | input | 27 | Lookup page number |
| lk_asid | input | 16 | Lookup ASID |
| lk_hit | output | 1 | Lookup found an entry |
| lk_ppn | output | 44 | Frame number of the found entry |
| done | output | 1 | Invalidation completed pulse |
| exc_illegal | output | 1 | Illegal-instruction pulse |
| exc_virtual | output | 1 | Virtual-instruction pulse |

## Verification
The assertions rely on a few things about the inputs. The privilege and virtualization inputs and the extension enables must be steady in the cycle a request is taken. `cur_priv` never takes the reserved value 2. Machine mode is never paired with `cur_virt` high. The bench changes its context inputs only while no request is in flight, and it drives only the three defined privilege codes. It raises `req_valid` only when the block is idle and drops it right after acceptance, so every request has exactly one expected outcome in the scoreboard queue.

// File: rtl/gtlb_pkg.sv
package gtlb_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        OUT_DONE    = 2'd0,
        OUT_ILLEGAL = 2'd1,
        OUT_VIRTUAL = 2'd2,
        OUT_NONE    = 2'd3
    } outcome_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_CLEAR = 1'b1
    } state_e;

    // Legality verdict; missing extensions rank first.
    function automatic outcome_e judge(input logic h_en, input logic inval_en,
                                       input logic virt, input logic [1:0] priv);
        if (!(h_en && inval_en))
            return OUT_ILLEGAL;
        if (virt && (priv == PRIV_U || priv == PRIV_S))
            return OUT_VIRTUAL;
        if (!virt && priv == PRIV_U)
            return OUT_ILLEGAL;
        return OUT_DONE;
    endfunction

endpackage

// File: rtl/gtlb_entry_match.sv
module gtlb_entry_match #(
    parameter int VPN_W  = 27,
    parameter int ASID_W = 16,
    parameter int VMID_W = 14
) (
    input  logic              e_valid,
    input  logic [VMID_W-1:0] e_vmid,
    input  logic [ASID_W-1:0] e_asid,
    input  logic [VPN_W-1:0]  e_vpn,
    input  logic              e_global,
    input  logic [VMID_W-1:0] c_vmid,
    input  logic [VPN_W-1:0]  c_vpn,
    input  logic [ASID_W-1:0] c_asid,
    input  logic              c_any_addr,
    input  logic              c_any_asid,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              inv_hit,
    output logic              lk_hit
);
    logic addr_sel, asid_sel;

    always_comb begin
        addr_sel = c_any_addr || (e_vpn == c_vpn);
        asid_sel = c_any_asid || (!e_global && (e_asid == c_asid));
        inv_hit  = e_valid && (e_vmid == c_vmid) && addr_sel && asid_sel;
        lk_hit   = e_valid && (e_vmid == cur_vmid) && (e_vpn == lk_vpn) &&
                   (e_global || (e_asid == lk_asid));
    end
endmodule

// File: rtl/gtlb_victim.sv
module gtlb_victim #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_ENTRIES-1:0] valid,
    input  logic                 advance,
    output logic [IDX_W-1:0]     victim
);
    logic [IDX_W-1:0] rr_q, first_free;
    logic             any_free;

    always_comb begin
        any_free   = 1'b0;
        first_free = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_free   = 1'b1;
                first_free = IDX_W'(i);
            end
        end
        victim = any_free ? first_free : rr_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            rr_q <= '0;
        else if (advance && !any_free)
            rr_q <= (rr_q == IDX_W'(N_ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
endmodule

// File: rtl/gtlb_ctrl.sv
module gtlb_ctrl
    import gtlb_pkg::*;
#(
    parameter int VPN_W  = 27,
    parameter int ASID_W = 16,
    parameter int VMID_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic              req_addr_x0,
    input  logic              req_asid_x0,
    input  logic [1:0]        cur_priv,
    input  logic              cur_virt,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic              ext_h_en,
    input  logic              ext_inval_en,
    output logic              req_ready,
    output logic              fill_ready,
    output logic              clear_en,
    output logic [VMID_W-1:0] c_vmid,
    output logic [VPN_W-1:0]  c_vpn,
    output logic [ASID_W-1:0] c_asid,
    output logic              c_any_addr,
    output logic              c_any_asid,
    output logic              done,
    output logic              exc_illegal,
    output logic              exc_virtual
);
    state_e   state_q;
    outcome_e verdict;

    always_comb begin
        verdict    = judge(ext_h_en, ext_inval_en, cur_virt, cur_priv);
        req_ready  = (state_q == ST_IDLE);
        fill_ready = (state_q == ST_IDLE) && !req_valid;
        clear_en   = (state_q == ST_CLEAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            done        <= 1'b0;
            exc_illegal <= 1'b0;
            exc_virtual <= 1'b0;
            c_vmid      <= '0;
            c_vpn       <= '0;
            c_asid      <= '0;
            c_any_addr  <= 1'b0;
            c_any_asid  <= 1'b0;
        end else begin
            done        <= 1'b0;
            exc_illegal <= 1'b0;
            exc_virtual <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        case (verdict)
                            OUT_DONE: begin
                                state_q    <= ST_CLEAR;
                                c_vmid     <= cur_vmid;
                                c_vpn      <= req_vpn;
                                c_asid     <= req_asid;
                                c_any_addr <= req_addr_x0;
                                c_any_asid <= req_asid_x0;
                            end
                            OUT_VIRTUAL: exc_virtual <= 1'b1;
                            default:     exc_illegal <= 1'b1;
                        endcase
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    done    <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/gvs_tlb_inval.sv
module gvs_tlb_inval #(
    parameter int N_ENTRIES = 8,
    parameter int XLEN      = 64,
    parameter int PG_SHIFT  = 12,
    parameter int VPN_W     = 27,
    parameter int ASID_W    = 16,
    parameter int VMID_W    = 14,
    parameter int PPN_W     = 44,
    localparam int ADDR_W   = VPN_W + PG_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]   req_asid_op,
    input  logic              req_addr_x0,
    input  logic              req_asid_x0,
    input  logic [1:0]        cur_priv,
    input  logic              cur_virt,
    input  logic [VMID_W-1:0] cur_vmid,
    input  logic              ext_h_en,
    input  logic              ext_inval_en,
    input  logic              fill_valid,
    output logic              fill_ready,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [PPN_W-1:0]  fill_ppn,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              done,
    output logic              exc_illegal,
    output logic              exc_virtual
);
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    logic [N_ENTRIES-1:0] e_valid, inv_hit, lk_match;
    logic [VMID_W-1:0]    e_vmid  [N_ENTRIES];
    logic [ASID_W-1:0]    e_asid  [N_ENTRIES];
    logic [VPN_W-1:0]     e_vpn   [N_ENTRIES];
    logic                 e_global[N_ENTRIES];
    logic [PPN_W-1:0]     e_ppn   [N_ENTRIES];

    logic              clear_en, c_any_addr, c_any_asid, fill_fire;
    logic [VMID_W-1:0] c_vmid;
    logic [VPN_W-1:0]  c_vpn;
    logic [ASID_W-1:0] c_asid;
    logic [IDX_W-1:0]  victim;
    logic              unused_op_bits;

    assign unused_op_bits = ^{req_addr[PG_SHIFT-1:0], req_asid_op[XLEN-1:ASID_W]};
    assign fill_fire      = fill_valid && fill_ready;

    gtlb_ctrl #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .req_vpn(req_addr[ADDR_W-1:PG_SHIFT]), .req_asid(req_asid_op[ASID_W-1:0]),
        .req_addr_x0(req_addr_x0), .req_asid_x0(req_asid_x0),
        .cur_priv(cur_priv), .cur_virt(cur_virt), .cur_vmid(cur_vmid),
        .ext_h_en(ext_h_en), .ext_inval_en(ext_inval_en),
        .req_ready(req_ready), .fill_ready(fill_ready), .clear_en(clear_en),
        .c_vmid(c_vmid), .c_vpn(c_vpn), .c_asid(c_asid),
        .c_any_addr(c_any_addr), .c_any_asid(c_any_asid),
        .done(done), .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
    );

    gtlb_victim #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst(rst), .valid(e_valid), .advance(fill_fire), .victim(victim)
    );

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        gtlb_entry_match #(.VPN_W(VPN_W), .ASID_W(ASID_W), .VMID_W(VMID_W)) u_match (
            .e_valid(e_valid[g]), .e_vmid(e_vmid[g]), .e_asid(e_asid[g]),
            .e_vpn(e_vpn[g]), .e_global(e_global[g]),
            .c_vmid(c_vmid), .c_vpn(c_vpn), .c_asid(c_asid),
            .c_any_addr(c_any_addr), .c_any_asid(c_any_asid),
            .cur_vmid(cur_vmid), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
            .inv_hit(inv_hit[g]), .lk_hit(lk_match[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            e_valid <= '0;
        end else if (clear_en) begin
            e_valid <= e_valid & ~inv_hit;
        end else if (fill_fire) begin
            e_valid[victim] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_fire) begin
            e_vmid[victim]   <= cur_vmid;
            e_asid[victim]   <= fill_asid;
            e_vpn[victim]    <= fill_vpn;
            e_global[victim] <= fill_global;
            e_ppn[victim]    <= fill_ppn;
        end
    end

    always_comb begin
        lk_hit = |lk_match;
        lk_ppn = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--)
            if (lk_match[i]) lk_ppn = e_ppn[i];
    end
endmodule

// File: rtl/gvs_tlb_inval_chk.sv
module gvs_tlb_inval_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic       fill_ready,
    input logic [1:0] cur_priv,
    input logic       cur_virt,
    input logic       ext_h_en,
    input logic       ext_inval_en,
    input logic       done,
    input logic       exc_illegal,
    input logic       exc_virtual
);
    logic take, ext_ok;
    assign take   = req_valid && req_ready;
    assign ext_ok = ext_h_en && ext_inval_en;

    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_clear_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!req_ready));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, exc_illegal, exc_virtual}));

    assert_fill_hold_busy_R10: assert property (@(posedge clk) disable iff (rst)
        !req_ready |-> !fill_ready);

    assert_fill_hold_take_R10: assert property (@(posedge clk) disable iff (rst)
        take |-> !fill_ready);

    assert_virtual_cause_R4: assert property (@(posedge clk) disable iff (rst)
        exc_virtual |-> $past(take && ext_ok && cur_virt && (cur_priv != 2'd3)));

    assert_ext_missing_R5: assert property (@(posedge clk) disable iff (rst)
        (take && !ext_ok) |=> exc_illegal);

    assert_user_plain_R6: assert property (@(posedge clk) disable iff (rst)
        (take && ext_ok && !cur_virt && (cur_priv == 2'd0)) |=> exc_illegal);
endmodule

bind gvs_tlb_inval gvs_tlb_inval_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .fill_ready(fill_ready), .cur_priv(cur_priv), .cur_virt(cur_virt),
    .ext_h_en(ext_h_en), .ext_inval_en(ext_inval_en),
    .done(done), .exc_illegal(exc_illegal), .exc_virtual(exc_virtual)
);

// File: tb/gvs_tlb_inval_tb.sv
module gvs_tlb_inval_tb;
    import gtlb_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ready;
    logic [38:0] req_addr = '0;
    logic [63:0] req_asid_op = '0;
    logic        req_addr_x0 = 1'b0, req_asid_x0 = 1'b0;
    logic [1:0]  cur_priv = 2'd1;
    logic        cur_virt = 1'b0;
    logic [13:0] cur_vmid = 14'd5;
    logic        ext_h_en = 1'b1, ext_inval_en = 1'b1;
    logic        fill_valid = 1'b0, fill_ready;
    logic [26:0] fill_vpn = '0;
    logic [15:0] fill_asid = '0;
    logic        fill_global = 1'b0;
    logic [43:0] fill_ppn = '0;
    logic [26:0] lk_vpn = '0;
    logic [15:0] lk_asid = '0;
    logic        lk_hit;
    logic [43:0] lk_ppn;
    logic        done, exc_illegal, exc_virtual;

    int checks = 0;
    int fails  = 0;
    outcome_e exp_q[$];

    gvs_tlb_inval u_dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_eq(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: each outcome pulse is matched against the queue.
    always @(negedge clk) begin
        if (!rst && (done || exc_illegal || exc_virtual)) begin
            outcome_e got;
            got = done ? OUT_DONE : (exc_illegal ? OUT_ILLEGAL : OUT_VIRTUAL);
            if (exp_q.size() == 0)
                check_eq("R9 unexpected outcome", got, OUT_NONE);
            else
                check_eq("R9 outcome kind", got, exp_q.pop_front());
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
    endtask

    task automatic fill(input logic [26:0] vpn, input logic [15:0] asid,
                        input logic glob, input logic [43:0] ppn);
        @(negedge clk);
        check_eq("R10 idle fill_ready", fill_ready, 1);
        fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid;
        fill_global = glob; fill_ppn = ppn;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic look(string tag, input logic [26:0] vpn, input logic [15:0] asid,
                        input logic exp_hit, input logic [43:0] exp_ppn);
        lk_vpn = vpn; lk_asid = asid;
        #1;
        check_eq({tag, " hit"}, lk_hit, exp_hit);
        if (exp_hit) check_eq({tag, " ppn"}, lk_ppn, exp_ppn);
    endtask

    task automatic issue(input logic [26:0] vpn, input logic [11:0] off,
                         input logic [15:0] asid, input logic ax0, input logic sx0,
                         input outcome_e exp);
        @(negedge clk);
        req_addr = {vpn, off}; req_asid_op = {48'hDEAD_0000_BEEF, asid};
        req_addr_x0 = ax0; req_asid_x0 = sx0;
        if (ax0) req_addr = '0;
        if (sx0) req_asid_op = '0;
        req_valid = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        req_valid = 1'b0;
        if (exp == OUT_DONE) begin
            check_eq("R10 fill_ready in clear cycle", fill_ready, 0);
            check_eq("R9 done not early", done, 0);
            @(negedge clk);
            check_eq("R9 done after clear", done, 1);
        end
        @(negedge clk);
        check_eq("R9 single pulse", done | exc_illegal | exc_virtual, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        check_eq("R9 reset done", done, 0);
        check_eq("R9 reset exc", exc_illegal | exc_virtual, 0);
        check_eq("R10 reset fill_ready", fill_ready, 1);
        look("R12 reset lookup", 27'h10, 16'd1, 0, 0);

        // R8: specific address with offset bits and specific ASID.
        fill(27'h10, 16'd1, 0, 44'h100);
        fill(27'h10, 16'd2, 0, 44'h101);
        fill(27'h11, 16'd1, 0, 44'h102);
        look("R12 filled", 27'h10, 16'd1, 1, 44'h100);
        look("R12 asid mismatch", 27'h10, 16'd3, 0, 0);
        issue(27'h10, 12'hABC, 16'd1, 0, 0, OUT_DONE);
        look("R8 target cleared", 27'h10, 16'd1, 0, 0);
        look("R8 other asid kept", 27'h10, 16'd2, 1, 44'h101);
        look("R8 other page kept", 27'h11, 16'd1, 1, 44'h102);

        // R1: address wildcard.
        do_reset();
        fill(27'h20, 16'd2, 0, 44'h200);
        fill(27'h21, 16'd2, 0, 44'h201);
        fill(27'h20, 16'd3, 0, 44'h202);
        issue(27'h0, 12'h0, 16'd2, 1, 0, OUT_DONE);
        look("R1 page 20 cleared", 27'h20, 16'd2, 0, 0);
        look("R1 page 21 cleared", 27'h21, 16'd2, 0, 0);
        look("R1 other asid kept", 27'h20, 16'd3, 1, 44'h202);

        // R7 and R2: global entries.
        do_reset();
        fill(27'h30, 16'd4, 0, 44'h302);
        fill(27'h30, 16'd1, 1, 44'h301);
        fill(27'h31, 16'd4, 0, 44'h303);
        look("R12 lowest index wins", 27'h30, 16'd4, 1, 44'h302);
        issue(27'h30, 12'h0, 16'd4, 0, 0, OUT_DONE);
        look("R7 global survives", 27'h30, 16'd4, 1, 44'h301);
        issue(27'h30, 12'h0, 16'd0, 0, 1, OUT_DONE);
        look("R2 global cleared", 27'h30, 16'd9, 0, 0);
        look("R2 other page kept", 27'h31, 16'd4, 1, 44'h303);

        // R3: VMID from context only.
        do_reset();
        fill(27'h40, 16'd1, 0, 44'h401);
        cur_vmid = 14'd6;
        fill(27'h40, 16'd1, 0, 44'h402);
        issue(27'h40, 12'h0, 16'd5, 1, 0, OUT_DONE);
        issue(27'h40, 12'h0, 16'd1, 0, 0, OUT_DONE);
        look("R3 own vmid cleared", 27'h40, 16'd1, 0, 0);
        cur_vmid = 14'd5;
        look("R3 other vmid kept", 27'h40, 16'd1, 1, 44'h401);

        // R4: virtualized supervisor and user.
        cur_virt = 1'b1; cur_priv = 2'd1;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_VIRTUAL);
        cur_priv = 2'd0;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_VIRTUAL);
        cur_virt = 1'b0; cur_priv = 2'd1;
        look("R4 entries unchanged", 27'h40, 16'd1, 1, 44'h401);

        // R5: extensions missing, checked ahead of the virtual case.
        ext_h_en = 1'b0;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_ILLEGAL);
        ext_h_en = 1'b1; ext_inval_en = 1'b0; cur_virt = 1'b1;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_ILLEGAL);
        ext_inval_en = 1'b1; cur_virt = 1'b0;
        look("R5 entries unchanged", 27'h40, 16'd1, 1, 44'h401);

        // R6: plain user mode, then machine mode legal.
        cur_priv = 2'd0;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_ILLEGAL);
        look("R6 entries unchanged", 27'h40, 16'd1, 1, 44'h401);
        cur_priv = 2'd3;
        issue(27'h0, 12'h0, 16'd0, 1, 1, OUT_DONE);
        look("R6 machine mode clears", 27'h40, 16'd1, 0, 0);
        cur_priv = 2'd1;

        // R10: a fill raised with the request waits for the clear.
        do_reset();
        fill(27'h70, 16'd1, 0, 44'h700);
        @(negedge clk);
        req_addr = {27'h70, 12'h0}; req_asid_op = 64'd1;
        req_addr_x0 = 1'b0; req_asid_x0 = 1'b0; req_valid = 1'b1;
        fill_valid = 1'b1; fill_vpn = 27'h70; fill_asid = 16'd1;
        fill_global = 1'b0; fill_ppn = 44'h701;
        exp_q.push_back(OUT_DONE);
        #1 check_eq("R10 fill_ready with request", fill_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        check_eq("R10 fill_ready clearing", fill_ready, 0);
        @(negedge clk);
        check_eq("R10 fill_ready after clear", fill_ready, 1);
        @(negedge clk);
        fill_valid = 1'b0;
        look("R10 held fill survives", 27'h70, 16'd1, 1, 44'h701);

        // R11: placement and round-robin replacement.
        do_reset();
        for (int i = 0; i < 8; i++)
            fill(27'h50 + 27'(i), 16'd1, 0, 44'h500 + 44'(i));
        look("R11 all eight present", 27'h57, 16'd1, 1, 44'h507);
        fill(27'h58, 16'd1, 0, 44'h508);
        look("R11 slot0 replaced", 27'h50, 16'd1, 0, 0);
        look("R11 new entry", 27'h58, 16'd1, 1, 44'h508);
        fill(27'h59, 16'd1, 0, 44'h509);
        look("R11 slot1 replaced", 27'h51, 16'd1, 0, 0);
        issue(27'h53, 12'h0, 16'd1, 0, 0, OUT_DONE);
        fill(27'h60, 16'd1, 0, 44'h600);
        look("R11 free slot used", 27'h60, 16'd1, 1, 44'h600);
        look("R11 slot2 kept", 27'h52, 16'd1, 1, 44'h502);
        look("R11 slot4 kept", 27'h54, 16'd1, 1, 44'h504);
        fill(27'h61, 16'd1, 0, 44'h601);
        look("R11 slot2 replaced", 27'h52, 16'd1, 0, 0);
        look("R11 newest entry", 27'h61, 16'd1, 1, 44'h601);

        repeat (3) @(negedge clk);
        check_eq("R9 outstanding outcomes", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule